// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block turns a vector of per-element condition bits into one branch decision. A single start pulse captures the vector length, the condition bits, a predicate mask and the mode controls. The block then walks the elements one per clock, starting at element 0. Elements are ignored when they lie outside the vector length or when their predicate bit is clear. Every other element is tested and folded into the decision, using either ALL semantics (every tested element must pass) or SOME semantics (at least one must pass).

Along the way the block can apply two side effects. It can decrease a count value by one for each active element, stopping at zero. It can also cut the vector length at the first active element whose test fails or, if selected, passes. Both side effects apply whether or not the branch is taken, so a branch aimed at the next instruction still updates the count and the length. With a vector length of one, element 0 predicated on and both side effects off, the result is an ordinary scalar conditional test.

The three results are registered. They are presented together with a one-cycle `done` pulse and hold until the next accepted start.

Top module: `vbe_eval`

## Requirements
- R1: After reset, `busy`, `done` and `taken` are 0, and `ctr_out` and `vl_out` are 0.
- R2: Element i (bit i of `cond_vec` and of `pred_vec`, bit 0 first) is active only when i is below the vector length and `pred_vec[i]` is 1. An active element passes when `cond_vec[i]` XOR `branch_on_fail` is 1. Inactive elements affect no result.
- R3: With `all_mode`=1, `taken` is 1 exactly when every scanned active element passes. When no element is active, `taken` is 1.
- R4: With `all_mode`=0, `taken` is 1 exactly when at least one scanned active element passes. When no element is active, `taken` is 0.
- R5: `branch_on_fail`=1 inverts every element's pass value, so the block branches on failing elements.
- R6: With `ctr_mode`=1, `ctr_out` equals `ctr_in` minus the number of scanned active elements, held at 0 rather than wrapping. With `ctr_mode`=0, `ctr_out` equals `ctr_in`.
- R7: With `trunc_en`=1, the scan ends at the first active element whose pass value equals `trunc_on_pass`. That element still counts toward `taken` and the count, later elements are ignored, and `vl_out` is its index. If no element triggers, `vl_out` equals the vector length.
- R8: Count mode and truncation may be enabled together. The count then covers only the active elements up to and including the truncation point.
- R9: A `vl_in` above MAXVL is treated as MAXVL.
- R10: `done` is a one-cycle pulse. It rises exactly `vl_out`+1 clock edges after the edge that accepts `start`. `busy` is high from the cycle after that edge until `done`. The results hold until the next accepted start.
- R11: A `start` while `busy` is high is ignored and does not change the run in progress.
- R12: With `vl_in`=1, `pred_vec[0]`=1, `ctr_mode`=0 and `trunc_en`=0, `taken` equals `cond_vec[0]` XOR `branch_on_fail` in either set mode, and the count and length come back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (accepted when idle) |
| vl_in | input | VLW | Vector length |
| cond_vec | input | MAXVL | Per-element condition bits, bit 0 = element 0 |
| pred_vec | input | MAXVL | Per-element predicate mask |
| all_mode | input | 1 | 1 = ALL semantics, 0 = SOME semantics |
| branch_on_fail | input | 1 | Invert element test sense |
| ctr_mode | input | 1 | Decrement count per active element |
| trunc_en | input | 1 | Enable vector-length truncation |
| trunc_on_pass | input | 1 | Truncate on passing (1) or failing (0) element |
| ctr_in | input | CTRW | Count value at start |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result-valid pulse |
| taken | output | 1 | Branch decision |
| ctr_out | output | CTRW | Updated count |
| vl_out | output | VLW | Updated vector length |

## Verification
A wrong scan index or a stale element latch shows up as a wrong `taken` or `vl_out` in the very run it occurs in. It also moves the `done` pulse away from its expected edge, so every run is timed against its expected `vl_out`+1 edges. A wrong count register appears in `ctr_out` at the `done` of the same run. A wrong set-mode accumulator is caught by placing a single differing element either inside or outside the length, or under a cleared predicate bit. A start that is wrongly accepted while busy changes that run's results or its completion time, and a dedicated case checks for this.

// File: rtl/vbe_pkg.sv
package vbe_pkg;

  typedef enum logic [0:0] {
    VBE_IDLE = 1'b0,
    VBE_SCAN = 1'b1
  } vbe_state_e;

  typedef struct packed {
    logic all_mode;
    logic on_fail;
    logic ctr_en;
    logic trunc_en;
    logic trunc_on_pass;
  } vbe_cfg_t;

endpackage

// File: rtl/vbe_elem_pick.sv
module vbe_elem_pick #(
  parameter int MAXVL = 8,
  parameter int IDXW  = $clog2(MAXVL + 1)
) (
  input  logic [MAXVL-1:0] cond_vec,
  input  logic [MAXVL-1:0] pred_vec,
  input  logic [IDXW-1:0]  idx,
  input  vbe_pkg::vbe_cfg_t cfg,
  output logic             act,
  output logic             pass,
  output logic             cut
);

  logic c_bit;
  logic p_bit;

  always_comb begin
    c_bit = 1'b0;
    p_bit = 1'b0;
    for (int i = 0; i < MAXVL; i++) begin
      if (idx == IDXW'(i)) begin
        c_bit = cond_vec[i];
        p_bit = pred_vec[i];
      end
    end
  end

  assign act  = p_bit;
  assign pass = c_bit ^ cfg.on_fail;
  assign cut  = act & cfg.trunc_en & (pass == cfg.trunc_on_pass);

endmodule

// File: rtl/vbe_set_acc.sv
module vbe_set_acc (
  input  logic acc_in,
  input  logic act,
  input  logic pass,
  input  logic all_mode,
  output logic acc_out
);

  always_comb begin
    if (all_mode) begin
      acc_out = acc_in & (pass | ~act);
    end else begin
      acc_out = acc_in | (act & pass);
    end
  end

endmodule

// File: rtl/vbe_sat_dec.sv
module vbe_sat_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic         en,
  output logic [W-1:0] res
);

  always_comb begin
    if (en && (val != '0)) begin
      res = val - W'(1);
    end else begin
      res = val;
    end
  end

  always_comb begin
    assert_dec_no_wrap_R6: assert (res <= val);
  end

endmodule

// File: rtl/vbe_eval.sv
module vbe_eval #(
  parameter int MAXVL = 8,
  parameter int CTRW  = 16,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl_in,
  input  logic [MAXVL-1:0] cond_vec,
  input  logic [MAXVL-1:0] pred_vec,
  input  logic             all_mode,
  input  logic             branch_on_fail,
  input  logic             ctr_mode,
  input  logic             trunc_en,
  input  logic             trunc_on_pass,
  input  logic [CTRW-1:0]  ctr_in,
  output logic             busy,
  output logic             done,
  output logic             taken,
  output logic [CTRW-1:0]  ctr_out,
  output logic [VLW-1:0]   vl_out
);

  import vbe_pkg::*;

  localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

  vbe_state_e        state_q, state_d;
  logic [VLW-1:0]    idx_q, idx_d;
  logic [VLW-1:0]    vl_q, vl_d;
  logic [MAXVL-1:0]  cond_q, cond_d;
  logic [MAXVL-1:0]  pred_q, pred_d;
  vbe_cfg_t          cfg_q, cfg_d;
  logic              acc_q, acc_d;
  logic [CTRW-1:0]   cnt_q, cnt_d;
  logic              taken_q, taken_d;
  logic [CTRW-1:0]   ctr_q, ctr_d;
  logic [VLW-1:0]    vlo_q, vlo_d;
  logic              done_q, done_d;

  logic              load_en;
  logic [VLW-1:0]    vl_clamped;
  vbe_cfg_t          cfg_in;
  logic              el_act;
  logic              el_pass;
  logic              el_cut;
  logic              acc_step;
  logic [CTRW-1:0]   cnt_step;

  assign load_en    = (state_q == VBE_IDLE) && start;
  assign vl_clamped = (vl_in > VL_MAX) ? VL_MAX : vl_in;

  always_comb begin
    cfg_in.all_mode      = all_mode;
    cfg_in.on_fail       = branch_on_fail;
    cfg_in.ctr_en        = ctr_mode;
    cfg_in.trunc_en      = trunc_en;
    cfg_in.trunc_on_pass = trunc_on_pass;
  end

  vbe_elem_pick #(
    .MAXVL(MAXVL),
    .IDXW (VLW)
  ) u_pick (
    .cond_vec(cond_q),
    .pred_vec(pred_q),
    .idx     (idx_q),
    .cfg     (cfg_q),
    .act     (el_act),
    .pass    (el_pass),
    .cut     (el_cut)
  );

  vbe_set_acc u_acc (
    .acc_in  (acc_q),
    .act     (el_act),
    .pass    (el_pass),
    .all_mode(cfg_q.all_mode),
    .acc_out (acc_step)
  );

  vbe_sat_dec #(
    .W(CTRW)
  ) u_dec (
    .val(cnt_q),
    .en (el_act & cfg_q.ctr_en),
    .res(cnt_step)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    vl_d    = vl_q;
    cond_d  = cond_q;
    pred_d  = pred_q;
    cfg_d   = cfg_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    taken_d = taken_q;
    ctr_d   = ctr_q;
    vlo_d   = vlo_q;
    done_d  = 1'b0;
    unique case (state_q)
      VBE_IDLE: begin
        if (load_en) begin
          state_d = VBE_SCAN;
          idx_d   = '0;
          vl_d    = vl_clamped;
          cond_d  = cond_vec;
          pred_d  = pred_vec;
          cfg_d   = cfg_in;
          acc_d   = all_mode;
          cnt_d   = ctr_in;
        end
      end
      VBE_SCAN: begin
        if (idx_q >= vl_q) begin
          state_d = VBE_IDLE;
          done_d  = 1'b1;
          taken_d = acc_q;
          ctr_d   = cnt_q;
          vlo_d   = vl_q;
        end else begin
          acc_d = acc_step;
          cnt_d = cnt_step;
          if (el_cut) begin
            state_d = VBE_IDLE;
            done_d  = 1'b1;
            taken_d = acc_step;
            ctr_d   = cnt_step;
            vlo_d   = idx_q;
          end else begin
            idx_d = idx_q + VLW'(1);
          end
        end
      end
      default: state_d = VBE_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VBE_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
      cond_q  <= '0;
      pred_q  <= '0;
      cfg_q   <= '0;
      acc_q   <= 1'b0;
      cnt_q   <= '0;
      taken_q <= 1'b0;
      ctr_q   <= '0;
      vlo_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      vl_q    <= vl_d;
      cond_q  <= cond_d;
      pred_q  <= pred_d;
      cfg_q   <= cfg_d;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      taken_q <= taken_d;
      ctr_q   <= ctr_d;
      vlo_q   <= vlo_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q == VBE_SCAN);
  assign done    = done_q;
  assign taken   = taken_q;
  assign ctr_out = ctr_q;
  assign vl_out  = vlo_q;

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_cnt_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == VBE_SCAN) |=> (cnt_q <= $past(cnt_q)));

  assert_vl_not_grown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (vlo_q <= vl_q));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == VBE_SCAN) && start) |=> ($stable(vl_q) && $stable(cfg_q) && $stable(cond_q)));

  assert_idx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == VBE_SCAN) |-> ((idx_q <= vl_q) && (vl_q <= VL_MAX)));

endmodule

// File: tb/vbe_eval_tb_top.sv
module vbe_eval_tb_top;

  localparam int MAXVL = 8;
  localparam int CTRW  = 16;
  localparam int VLW   = $clog2(MAXVL + 1);

  typedef struct packed {
    logic [31:0]      tag;
    logic [VLW-1:0]   vl;
    logic [MAXVL-1:0] cond;
    logic [MAXVL-1:0] pred;
    logic             all_m;
    logic             onf;
    logic             ctre;
    logic             trn;
    logic             tps;
    logic [CTRW-1:0]  ctr;
    logic             e_tk;
    logic [CTRW-1:0]  e_ctr;
    logic [VLW-1:0]   e_vl;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{"R3  ", 4'd4,  8'h0F, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,  1'b1, 16'd10, 4'd4},
    '{"R3  ", 4'd4,  8'h0B, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,  1'b0, 16'd10, 4'd4},
    '{"R2  ", 4'd4,  8'h0B, 8'hFB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,  1'b1, 16'd10, 4'd4},
    '{"R4  ", 4'd5,  8'h20, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,  1'b0, 16'd10, 4'd5},
    '{"R4  ", 4'd6,  8'h20, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,  1'b1, 16'd10, 4'd6},
    '{"R3  ", 4'd3,  8'h00, 8'hF8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,  1'b1, 16'd10, 4'd3},
    '{"R4  ", 4'd3,  8'hFF, 8'hF8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,  1'b0, 16'd10, 4'd3},
    '{"R5  ", 4'd4,  8'h00, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd10,  1'b1, 16'd10, 4'd4},
    '{"R5  ", 4'd4,  8'h0F, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd10,  1'b0, 16'd10, 4'd4},
    '{"R6  ", 4'd8,  8'h55, 8'hB5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd20,  1'b1, 16'd15, 4'd8},
    '{"R6  ", 4'd8,  8'h55, 8'hB5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd3,   1'b1, 16'd0,  4'd8},
    '{"R6  ", 4'd8,  8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd5,   1'b1, 16'd5,  4'd8},
    '{"R7  ", 4'd8,  8'hF7, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd9,   1'b0, 16'd9,  4'd3},
    '{"R7  ", 4'd8,  8'h10, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd9,   1'b1, 16'd9,  4'd4},
    '{"R7  ", 4'd8,  8'hF7, 8'hF7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd9,   1'b1, 16'd9,  4'd8},
    '{"R8  ", 4'd8,  8'hDF, 8'h7F, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'd100, 1'b0, 16'd94, 4'd5},
    '{"R9  ", 4'd12, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd50,  1'b1, 16'd42, 4'd8},
    '{"R12 ", 4'd1,  8'h01, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd7,   1'b1, 16'd7,  4'd1},
    '{"R12 ", 4'd1,  8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd7,   1'b1, 16'd7,  4'd1},
    '{"R12 ", 4'd1,  8'h01, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd7,   1'b0, 16'd7,  4'd1},
    '{"R10 ", 4'd0,  8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd4,   1'b1, 16'd4,  4'd0}
  };

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [VLW-1:0]   vl_in;
  logic [MAXVL-1:0] cond_vec;
  logic [MAXVL-1:0] pred_vec;
  logic             all_mode;
  logic             branch_on_fail;
  logic             ctr_mode;
  logic             trunc_en;
  logic             trunc_on_pass;
  logic [CTRW-1:0]  ctr_in;
  logic             busy;
  logic             done;
  logic             taken;
  logic [CTRW-1:0]  ctr_out;
  logic [VLW-1:0]   vl_out;

  int n_chk;
  int n_fail;

  vbe_eval #(.MAXVL(MAXVL), .CTRW(CTRW)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .vl_in         (vl_in),
    .cond_vec      (cond_vec),
    .pred_vec      (pred_vec),
    .all_mode      (all_mode),
    .branch_on_fail(branch_on_fail),
    .ctr_mode      (ctr_mode),
    .trunc_en      (trunc_en),
    .trunc_on_pass (trunc_on_pass),
    .ctr_in        (ctr_in),
    .busy          (busy),
    .done          (done),
    .taken         (taken),
    .ctr_out       (ctr_out),
    .vl_out        (vl_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    vl_in          = v.vl;
    cond_vec       = v.cond;
    pred_vec       = v.pred;
    all_mode       = v.all_m;
    branch_on_fail = v.onf;
    ctr_mode       = v.ctre;
    trunc_en       = v.trn;
    trunc_on_pass  = v.tps;
    ctr_in         = v.ctr;
  endtask

  // issue one start at a negedge; returns edges from accepting edge to done
  task automatic run(input vec_t v, input bit poke, input vec_t other, output int cyc);
    apply(v);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40) begin
      if (poke && cyc == 2) begin
        apply(other);
        start = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    vec_t ldr;
    vec_t oth;
    string tg;
    n_chk  = 0;
    n_fail = 0;
    start  = 1'b0;
    apply(TBL[0]);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "taken", int'(taken), 0);
    chk("R1", "ctr_out", int'(ctr_out), 0);
    chk("R1", "vl_out", int'(vl_out), 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      tg = string'(TBL[k].tag);
      run(TBL[k], 1'b0, TBL[k], cyc);
      chk(tg, "taken", int'(taken), int'(TBL[k].e_tk));
      chk(tg, "ctr_out", int'(ctr_out), int'(TBL[k].e_ctr));
      chk(tg, "vl_out", int'(vl_out), int'(TBL[k].e_vl));
      chk("R10", "latency", cyc, int'(TBL[k].e_vl) + 1);
      @(negedge clk);
      chk("R10", "done width", int'(done), 0);
    end

    // R10 busy during scan, results held after done
    ldr = TBL[15];
    apply(ldr);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy after start", int'(busy), 1);
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10", "busy after done", int'(busy), 0);
    chk("R10", "held taken", int'(taken), 0);
    chk("R10", "held ctr_out", int'(ctr_out), 94);
    chk("R10", "held vl_out", int'(vl_out), 5);

    // R11 start while busy ignored
    oth = TBL[17];
    run(TBL[9], 1'b1, oth, cyc);
    chk("R11", "taken", int'(taken), 1);
    chk("R11", "ctr_out", int'(ctr_out), 15);
    chk("R11", "vl_out", int'(vl_out), 8);
    chk("R11", "latency", cyc, 9);
    @(negedge clk);
    chk("R11", "no second run", int'(busy), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule